// File: doc/BRIEF.md
# PRBS-7 Self-Test Pattern Generator and Checker

This block adds a built-in self-test to a 10-bit parallel transceiver datapath. With the test enable low, the user's transmit word passes straight through to the transmit output and the status output rests high. With the test enable high, a seven-bit pseudorandom generator takes over the transmit output, producing ten sequence bits per word clock, and the user's transmit word is ignored.

On the receive side, a checker sees the incoming 10-bit words. It first fills its history from received bits and then predicts each following word from the bits it has already received. Because it locks onto whatever arrives, the result does not depend on how many cycles the loop between transmit and receive takes. Each compared word yields a pass or fail. A mode input chooses between a live status, which shows only the latest compared word, and a sticky status, which holds the first failure until the test enable is dropped.

Top module: `prbs7_bist`

## Requirements
- R1: The generator follows the recurrence b[n] = b[n-7] XOR b[n-6] (polynomial x^7 + x^6 + 1). The sequence repeats every 127 bits. Each word carries ten consecutive bits, with word bit 0 the earliest. The first word after the enable rises is computed from seven preceding bits that are all 1, so the first word is 10'h040.
- R2: While test_en is low, tx_word equals tx_user in the same cycle.
- R3: While test_en is high, tx_word carries successive generated words, one per clock, and tx_user has no effect on tx_word.
- R4: The checker loads its history on the first enabled word and does not compare it. Each later word is compared against the prediction. A mismatch drives pass low in the cycle after that word is sampled.
- R5: With hold_mode low, pass shows the result of the last compared word only. After a word that matches, pass returns high. A flip of rx_word bit 0 spoils only its own word's comparison, because bit 0 of a word never enters the history.
- R6: With hold_mode high, pass stays low after a failure for as long as test_en stays high, including over words that match.
- R7: Dropping test_en makes pass high one clock later and clears a held failure. The generator restarts, so the first word after re-enabling is again 10'h040.
- R8: With any fixed transmit-to-receive delay, the checker reports pass on a clean looped-back stream once it has loaded its history.
- R9: A history of all zeros counts as a mismatch, so a stuck-at-zero receive path cannot pass.
- R10: After reset, pass is high and the generator sits at its all-ones start state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_en | input | 1 | Enables the generator and the checker together |
| hold_mode | input | 1 | 0: live status, 1: sticky failure |
| tx_user | input | 10 | User transmit word |
| tx_word | output | 10 | Transmit word to the serializer |
| rx_word | input | 10 | Received word from the deserializer |
| pass | output | 1 | 1 = pass, 0 = mismatch seen |

## Verification
The hardest situation to reach from the ports is a checker locked onto a stream that comes back several cycles late, while the loop still holds stale user words from before the enable. The bench routes tx_word through its own three-stage delay line, lets the checker settle in live mode, and only then switches to sticky mode, so that any later false failure would stay visible. Error injection flips only bit 0 of a single word, which yields exactly one bad comparison and gives a precise recovery cycle for live mode. A forced all-zero receive stream covers the lockup case, which the prediction alone would accept.

// File: rtl/prbs7_pkg.sv
package prbs7_pkg;
  localparam int PRBS_W = 7;
  localparam int WORD_W = 10;
  localparam int TAP_A  = 6;   // bit n-7
  localparam int TAP_B  = 5;   // bit n-6

  // State convention: s[0] newest bit, s[PRBS_W-1] oldest bit.
  function automatic logic [WORD_W-1:0] prbs_word(input logic [PRBS_W-1:0] s_in);
    logic [PRBS_W-1:0] s;
    logic [WORD_W-1:0] w;
    logic b;
    s = s_in;
    w = '0;
    for (int i = 0; i < WORD_W; i++) begin
      b    = s[TAP_A] ^ s[TAP_B];
      w[i] = b;
      s    = {s[PRBS_W-2:0], b};
    end
    return w;
  endfunction

  function automatic logic [PRBS_W-1:0] prbs_adv(input logic [PRBS_W-1:0] s_in);
    logic [PRBS_W-1:0] s;
    logic b;
    s = s_in;
    for (int i = 0; i < WORD_W; i++) begin
      b = s[TAP_A] ^ s[TAP_B];
      s = {s[PRBS_W-2:0], b};
    end
    return s;
  endfunction

  // History after shifting in a received word, bit 0 first.
  function automatic logic [PRBS_W-1:0] hist_after(input logic [PRBS_W-1:0] h_in,
                                                   input logic [WORD_W-1:0] w);
    logic [PRBS_W-1:0] h;
    h = h_in;
    for (int i = 0; i < WORD_W; i++) h = {h[PRBS_W-2:0], w[i]};
    return h;
  endfunction
endpackage

// File: rtl/prbs7_gen.sv
module prbs7_gen
  import prbs7_pkg::*;
#(
  parameter logic [PRBS_W-1:0] SEED = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  output logic [WORD_W-1:0] word
);
  logic [PRBS_W-1:0] st;
  logic              gen_step;

  assign gen_step = en;
  assign word     = prbs_word(st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        st <= SEED;
    else if (!gen_step) st <= SEED;
    else               st <= prbs_adv(st);
  end

  // R1: state never reaches the lockup value
  a_r1_no_lockup: assert property (@(posedge clk) disable iff (!rst_n) st != '0);
  // R7: idle generator presents the restart word
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (word == prbs_word(SEED)));
endmodule

// File: rtl/prbs7_chk.sv
module prbs7_chk
  import prbs7_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              hold,
  input  logic [WORD_W-1:0] rx,
  output logic              pass,
  output logic              chk_cmp,
  output logic              chk_mis
);
  logic [PRBS_W-1:0] hist;
  logic              primed;
  logic [WORD_W-1:0] expect_w;

  assign expect_w = prbs_word(hist);
  assign chk_cmp  = en && primed;
  assign chk_mis  = (rx != expect_w) || (hist == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist   <= '0;
      primed <= 1'b0;
      pass   <= 1'b1;
    end else if (!en) begin
      primed <= 1'b0;
      pass   <= 1'b1;
    end else begin
      hist   <= hist_after(hist, rx);
      primed <= 1'b1;
      if (primed) pass <= hold ? (pass & ~chk_mis) : ~chk_mis;
    end
  end

  // R4: a failed comparison shows as pass low next cycle
  a_r4_fail_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_cmp && chk_mis) |=> !pass);
  // R4: the first enabled word is only loaded
  a_r4_no_first_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> !chk_cmp);
  // R5: live mode recovers on a matching word
  a_r5_live_recover: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_cmp && !chk_mis && !hold) |=> pass);
  // R6: sticky failure stays while enabled
  a_r6_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hold && !pass) |=> !pass);
  // R7: disabled test reports pass
  a_r7_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> pass);
endmodule

// File: rtl/prbs7_bist.sv
module prbs7_bist
  import prbs7_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_en,
  input  logic              hold_mode,
  input  logic [WORD_W-1:0] tx_user,
  output logic [WORD_W-1:0] tx_word,
  input  logic [WORD_W-1:0] rx_word,
  output logic              pass
);
  logic [WORD_W-1:0] gen_word;
  logic              chk_cmp;
  logic              chk_mis;

  prbs7_gen #(.SEED('1)) u_gen (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (test_en),
    .word (gen_word)
  );

  prbs7_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (test_en),
    .hold   (hold_mode),
    .rx     (rx_word),
    .pass   (pass),
    .chk_cmp(chk_cmp),
    .chk_mis(chk_mis)
  );

  assign tx_word = test_en ? gen_word : tx_user;

  // R3: while enabled the output word never equals a changed user word by reuse
  a_r3_user_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && $past(test_en) && !$stable(tx_user)) |-> (tx_word == gen_word));
endmodule

// File: tb/sim_prbs7_bist.sv
`timescale 1ns/1ps
module sim_prbs7_bist;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       test_en = 1'b0;
  logic       hold_mode = 1'b0;
  logic [9:0] tx_user = 10'h000;
  logic [9:0] tx_word;
  logic [9:0] rx_word;
  logic       pass;
  logic [1:0] rx_sel = 2'd0;
  logic [9:0] err = 10'h000;
  logic [9:0] d1 = 10'h0, d2 = 10'h0, d3 = 10'h0;
  logic       seq [0:126];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  prbs7_bist u0 (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .hold_mode(hold_mode),
    .tx_user(tx_user), .tx_word(tx_word), .rx_word(rx_word), .pass(pass)
  );

  always @(posedge clk) begin
    d1 <= tx_word;
    d2 <= d1;
    d3 <= d2;
  end

  assign rx_word = (rx_sel == 2'd0) ? (tx_word ^ err) :
                   (rx_sel == 2'd1) ? d3 : 10'h000;

  function automatic logic [9:0] exp_word(input int k);
    logic [9:0] w;
    for (int i = 0; i < 10; i++) w[i] = seq[(10 * k + i) % 127];
    return w;
  endfunction

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic t_reset();
    chk("R10 pass after reset", {9'b0, pass}, 10'h001);
    tx_user = 10'h2A5;
    #1;
    chk("R2 bypass at reset", tx_word, 10'h2A5);
  endtask

  task automatic t_bypass();
    for (int k = 0; k < 4; k++) begin
      tx_user = 10'(k * 199 + 3);
      cyc();
      chk("R2 bypass word", tx_word, 10'(k * 199 + 3));
    end
    chk("R7 pass idle", {9'b0, pass}, 10'h001);
  endtask

  task automatic t_gen();
    int bad = 0;
    test_en = 1'b1; hold_mode = 1'b0; rx_sel = 2'd0;
    #1;
    chk("R1 first word", tx_word, 10'h040);
    for (int k = 0; k < 131; k++) begin
      tx_user = 10'(k * 37 + 11);
      #1;
      if (tx_word !== exp_word(k)) begin
        bad++;
        $display("FAIL R3 word %0d actual=%h expected=%h", k, tx_word, exp_word(k));
      end
      if (k >= 2 && pass !== 1'b1) begin
        bad++;
        $display("FAIL R4 clean loop word %0d actual=%b expected=1", k, pass);
      end
      cyc();
    end
    checks++;
    if (bad != 0) fails++;
    chk("R1 period 127 words", exp_word(127), exp_word(0));
    test_en = 1'b0;
    cyc();
  endtask

  task automatic t_live();
    test_en = 1'b1; hold_mode = 1'b0; rx_sel = 2'd0;
    repeat (5) cyc();
    err = 10'h001;
    cyc();
    err = 10'h000;
    chk("R4 mismatch flagged", {9'b0, pass}, 10'h000);
    cyc();
    chk("R5 live recovers", {9'b0, pass}, 10'h001);
    test_en = 1'b0;
    cyc();
  endtask

  task automatic t_sticky();
    test_en = 1'b1; hold_mode = 1'b1; rx_sel = 2'd0;
    repeat (5) cyc();
    chk("R6 clean before error", {9'b0, pass}, 10'h001);
    err = 10'h001;
    cyc();
    err = 10'h000;
    chk("R6 failure seen", {9'b0, pass}, 10'h000);
    repeat (20) cyc();
    chk("R6 failure held", {9'b0, pass}, 10'h000);
    test_en = 1'b0;
    cyc();
    chk("R7 cleared by disable", {9'b0, pass}, 10'h001);
    test_en = 1'b1;
    #1;
    chk("R7 generator restart", tx_word, 10'h040);
    repeat (6) cyc();
    chk("R7 clean after restart", {9'b0, pass}, 10'h001);
    test_en = 1'b0; hold_mode = 1'b0;
    cyc();
  endtask

  task automatic t_delay();
    test_en = 1'b1; hold_mode = 1'b0; rx_sel = 2'd1;
    repeat (8) cyc();
    hold_mode = 1'b1;
    repeat (40) cyc();
    chk("R8 delayed loop passes", {9'b0, pass}, 10'h001);
    test_en = 1'b0; hold_mode = 1'b0; rx_sel = 2'd0;
    cyc();
  endtask

  task automatic t_zero();
    test_en = 1'b1; hold_mode = 1'b0; rx_sel = 2'd2;
    cyc();
    chk("R4 no compare on load", {9'b0, pass}, 10'h001);
    cyc();
    chk("R9 zero stream fails", {9'b0, pass}, 10'h000);
    test_en = 1'b0; rx_sel = 2'd0;
    cyc();
  endtask

  initial begin
    logic ext [0:133];
    for (int n = 0; n < 7; n++) ext[n] = 1'b1;
    for (int n = 7; n < 134; n++) ext[n] = ext[n - 7] ^ ext[n - 6];
    for (int n = 0; n < 127; n++) seq[n] = ext[n + 7];
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_bypass();
    t_gen();
    t_live();
    t_sticky();
    t_delay();
    t_zero();
    done = 1;
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_up();
    end
  end
endmodule